// File: doc/BRIEF.md
# Asynchronous Parallel Bus Master with Boot-Aware Timing

This block runs single read and write transfers from a synchronous system domain to a slave on an asynchronous parallel bus. The bus has an active-low chip select, separate active-low read and write strobes, an address bus, and a data bus split into an output, an output enable and an input. A transfer is requested over a valid/ready handshake. When it finishes, the block raises a one-cycle response pulse. For reads, that pulse carries the captured data.

Each bus phase is timed by a down counter that counts system clock cycles. Every nanosecond limit is a parameter given in picoseconds. Each limit is converted to cycles by rounding up. The minimum active width and the recovery gap both depend on the slave's own clock period, and that period is slower while the slave boots. The `boot_done` input therefore chooses one of two timing profiles. The choice is captured when a request is accepted and holds for that whole transfer.

Back-pressure rules: `req_ready` is high only while the block is idle. A request is taken on a cycle where both `req_valid` and `req_ready` are high. A requester holding `req_valid` during a transfer is not served until `req_ready` returns. The response side has no back-pressure: `rsp_valid` is a single-cycle pulse and must be taken when it appears.

Top module: `hbus_master`

## Requirements
- R1: `req_ready` equals the inverse of `busy`. `busy` is high from the cycle after a request is accepted until the recovery gap has elapsed. A `req_valid` asserted while busy starts no transfer, either then or after the block returns to idle, provided it is dropped before then.
- R2: `bus_cs_n` is low exactly when one strobe is low. The two strobes are never low together. A read lowers only `bus_rd_n` and a write lowers only `bus_wr_n`.
- R3: After acceptance, `bus_addr` shows the request address for ceil(5 ns / Tclk) cycles before the active phase starts. With the defaults (4 ns clock) this is 2 cycles.
- R4: The active phase (chip select and strobe low) lasts the largest of ceil((Ps + 10 ns)/Tclk), ceil(21 ns/Tclk) and ceil(20 ns/Tclk) cycles, where Ps is the slave period of the profile in use. With the defaults this is 28 cycles in the boot profile and 7 in the run profile.
- R5: After the active phase, `busy` stays high for ceil((2*Ps + 10 ns)/Tclk) cycles: 53 in the boot profile and 11 in the run profile. `bus_addr` does not change while busy.
- R6: For writes, `bus_data_oe` is high and `bus_data_o` holds the write data through the setup and active phases and for ceil(5 ns/Tclk) = 2 cycles afterwards, then goes low. For reads, `bus_data_oe` is never high.
- R7: A read samples `bus_data_i` on the last cycle of the active phase. `rsp_valid` is high for exactly the first cycle after the active phase of every transfer. On reads, `rsp_rdata` then holds the sampled value.
- R8: `boot_done` = 0 selects the boot slave period (default 100 ns) and 1 selects the run period (default 15.4 ns). The value is captured at acceptance, and a change during a transfer does not alter that transfer's timing.
- R9: During and right after reset: `bus_cs_n`, `bus_rd_n` and `bus_wr_n` are high, `bus_data_oe`, `busy` and `rsp_valid` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_done | input | 1 | 0: slave still booting (slow profile), 1: slave running (fast profile) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Transfer address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_valid on reads |
| busy | output | 1 | Transfer or recovery gap in progress |
| bus_cs_n | output | 1 | Bus chip select, active low |
| bus_rd_n | output | 1 | Bus read strobe, active low |
| bus_wr_n | output | 1 | Bus write strobe, active low |
| bus_addr | output | ADDR_W | Bus address |
| bus_data_o | output | DATA_W | Bus data driven by the master |
| bus_data_oe | output | 1 | Enable for bus_data_o onto the shared data bus |
| bus_data_i | input | DATA_W | Bus data driven by the slave |

## Verification
The assertions check, on every cycle, that the strobes stay legal, that `req_ready` tracks `busy`, that the address holds while busy, that no output enable overlaps a read strobe, that every response pulse follows the end of an active phase, and that no active phase is shorter than the fast-profile minimum. Only the directed scenarios can show the exact phase lengths for each profile, the capture of the profile at acceptance, the correct read data and its sampling cycle, the exact write-hold window, and that a request made while busy is dropped.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_GAP    = 2'd3
  } phase_e;

  // Whole system cycles covering a duration in picoseconds, rounded up.
  function automatic int unsigned ps_to_cyc(input int unsigned dur_ps,
                                            input int unsigned clk_ps);
    return (dur_ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/hbus_phase_ctr.sv
module hbus_phase_ctr #(
  parameter int unsigned CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          last
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  // A phase loaded with N spans N cycles; the final one sees cnt == 1.
  assign last = (cnt == CW'(1));
endmodule

// File: rtl/hbus_timing.sv
module hbus_timing #(
  parameter int unsigned CW       = 6,
  parameter int unsigned ACT_BOOT = 28,
  parameter int unsigned ACT_RUN  = 7,
  parameter int unsigned GAP_BOOT = 53,
  parameter int unsigned GAP_RUN  = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic          boot_done,
  output logic [CW-1:0] act_len,
  output logic [CW-1:0] gap_len
);
  // The profile is frozen per transfer so a mid-transfer change is harmless.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_len <= CW'(ACT_BOOT);
      gap_len <= CW'(GAP_BOOT);
    end else if (capture) begin
      act_len <= boot_done ? CW'(ACT_RUN) : CW'(ACT_BOOT);
      gap_len <= boot_done ? CW'(GAP_RUN) : CW'(GAP_BOOT);
    end
  end
endmodule

// File: rtl/hbus_seq.sv
module hbus_seq
  import hbus_pkg::*;
#(
  parameter int unsigned CW        = 6,
  parameter int unsigned SETUP_CYC = 2,
  parameter int unsigned HOLD_CYC  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [CW-1:0] act_len,
  input  logic [CW-1:0] gap_len,
  output logic          accept,
  output logic          sample,
  output logic          busy,
  output logic          done,
  output logic          cs_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic          oe
);
  localparam int unsigned HW = $clog2(HOLD_CYC + 2);

  phase_e        phase;
  logic          wr_q;
  logic [HW-1:0] hold_left;
  logic          ctr_load;
  logic [CW-1:0] ctr_val;
  logic          ctr_last;

  assign accept = (phase == PH_IDLE) && req_valid;
  assign busy   = (phase != PH_IDLE);
  assign sample = (phase == PH_ACTIVE) && ctr_last && !wr_q;

  always_comb begin
    ctr_load = 1'b0;
    ctr_val  = '0;
    if (accept) begin
      ctr_load = 1'b1;
      ctr_val  = CW'(SETUP_CYC);
    end else if (phase == PH_SETUP && ctr_last) begin
      ctr_load = 1'b1;
      ctr_val  = act_len;
    end else if (phase == PH_ACTIVE && ctr_last) begin
      ctr_load = 1'b1;
      ctr_val  = gap_len;
    end
  end

  hbus_phase_ctr #(.CW(CW)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ctr_load),
    .load_val (ctr_val),
    .last     (ctr_last)
  );

  // Bus controls are registered so the strobes leave flops without decode glitches.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      wr_q      <= 1'b0;
      hold_left <= '0;
      done      <= 1'b0;
      cs_n      <= 1'b1;
      rd_n      <= 1'b1;
      wr_n      <= 1'b1;
      oe        <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (req_valid) begin
            phase <= PH_SETUP;
            wr_q  <= req_write;
            oe    <= req_write;
          end
        end
        PH_SETUP: begin
          if (ctr_last) begin
            phase <= PH_ACTIVE;
            cs_n  <= 1'b0;
            rd_n  <= wr_q;
            wr_n  <= !wr_q;
          end
        end
        PH_ACTIVE: begin
          if (ctr_last) begin
            phase     <= PH_GAP;
            cs_n      <= 1'b1;
            rd_n      <= 1'b1;
            wr_n      <= 1'b1;
            done      <= 1'b1;
            hold_left <= HW'(HOLD_CYC);
            if (HOLD_CYC == 0) oe <= 1'b0;
          end
        end
        PH_GAP: begin
          if (hold_left != '0) begin
            hold_left <= hold_left - 1'b1;
            if (hold_left == HW'(1)) oe <= 1'b0;
          end
          if (ctr_last) begin
            phase <= PH_IDLE;
            oe    <= 1'b0;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hbus_master.sv
module hbus_master
  import hbus_pkg::*;
#(
  parameter int unsigned ADDR_W        = 8,
  parameter int unsigned DATA_W        = 16,
  parameter int unsigned SYS_CLK_PS    = 4000,
  parameter int unsigned BOOT_SLV_PS   = 100000,
  parameter int unsigned RUN_SLV_PS    = 15400,
  parameter int unsigned ADDR_SU_PS    = 5000,
  parameter int unsigned ADDR_HLD_PS   = 5000,
  parameter int unsigned STROBE_ADD_PS = 10000,
  parameter int unsigned RD_VALID_PS   = 21000,
  parameter int unsigned WR_SU_PS      = 20000,
  parameter int unsigned WR_HLD_PS     = 5000,
  parameter int unsigned GAP_ADD_PS    = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_done,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              busy,
  output logic              bus_cs_n,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              bus_data_oe,
  input  logic [DATA_W-1:0] bus_data_i
);
  localparam int unsigned SETUP_CYC = umax(1, ps_to_cyc(ADDR_SU_PS, SYS_CLK_PS));
  localparam int unsigned HOLD_CYC  = umax(ps_to_cyc(ADDR_HLD_PS, SYS_CLK_PS),
                                           ps_to_cyc(WR_HLD_PS, SYS_CLK_PS));
  localparam int unsigned ACT_FLOOR = umax(ps_to_cyc(RD_VALID_PS, SYS_CLK_PS),
                                           ps_to_cyc(WR_SU_PS, SYS_CLK_PS));
  localparam int unsigned ACT_BOOT  = umax(1, umax(ACT_FLOOR,
                                      ps_to_cyc(BOOT_SLV_PS + STROBE_ADD_PS, SYS_CLK_PS)));
  localparam int unsigned ACT_RUN   = umax(1, umax(ACT_FLOOR,
                                      ps_to_cyc(RUN_SLV_PS + STROBE_ADD_PS, SYS_CLK_PS)));
  localparam int unsigned GAP_BOOT  = umax(1, umax(HOLD_CYC,
                                      ps_to_cyc(2 * BOOT_SLV_PS + GAP_ADD_PS, SYS_CLK_PS)));
  localparam int unsigned GAP_RUN   = umax(1, umax(HOLD_CYC,
                                      ps_to_cyc(2 * RUN_SLV_PS + GAP_ADD_PS, SYS_CLK_PS)));
  localparam int unsigned LEN_MAX   = umax(umax(SETUP_CYC, umax(ACT_BOOT, ACT_RUN)),
                                           umax(GAP_BOOT, GAP_RUN));
  localparam int unsigned CW        = $clog2(LEN_MAX + 1);

  logic          accept;
  logic          sample;
  logic [CW-1:0] act_len;
  logic [CW-1:0] gap_len;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;

  hbus_timing #(
    .CW       (CW),
    .ACT_BOOT (ACT_BOOT),
    .ACT_RUN  (ACT_RUN),
    .GAP_BOOT (GAP_BOOT),
    .GAP_RUN  (GAP_RUN)
  ) u_timing (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (accept),
    .boot_done (boot_done),
    .act_len   (act_len),
    .gap_len   (gap_len)
  );

  hbus_seq #(
    .CW        (CW),
    .SETUP_CYC (SETUP_CYC),
    .HOLD_CYC  (HOLD_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .act_len   (act_len),
    .gap_len   (gap_len),
    .accept    (accept),
    .sample    (sample),
    .busy      (busy),
    .done      (rsp_valid),
    .cs_n      (bus_cs_n),
    .rd_n      (bus_rd_n),
    .wr_n      (bus_wr_n),
    .oe        (bus_data_oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (sample) rdata_q <= bus_data_i;
    end
  end

  assign req_ready  = !busy;
  assign bus_addr   = addr_q;
  assign bus_data_o = wdata_q;
  assign rsp_rdata  = rdata_q;
endmodule

// File: rtl/hbus_checker.sv
module hbus_checker #(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned MIN_ACT = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              busy,
  input logic              rsp_valid,
  input logic              bus_cs_n,
  input logic              bus_rd_n,
  input logic              bus_wr_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_data_oe
);
  logic [15:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         low_run <= '0;
    else if (!bus_cs_n) low_run <= low_run + 1'b1;
    else                low_run <= '0;
  end

  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n));

  a_r2_cs_match: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n || !bus_wr_n) == !bus_cs_n);

  a_r1_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready == !busy);

  a_r5_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(bus_addr));

  a_r6_no_oe_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> !bus_data_oe);

  a_r7_done_after_active: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (bus_cs_n && !$past(bus_cs_n)));

  a_r4_min_active: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_cs_n) |-> (low_run >= 16'(MIN_ACT)));
endmodule

bind hbus_master hbus_checker #(
  .ADDR_W  (ADDR_W),
  .MIN_ACT (ACT_RUN)
) u_hbus_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .busy        (busy),
  .rsp_valid   (rsp_valid),
  .bus_cs_n    (bus_cs_n),
  .bus_rd_n    (bus_rd_n),
  .bus_wr_n    (bus_wr_n),
  .bus_addr    (bus_addr),
  .bus_data_oe (bus_data_oe)
);

// File: tb/test_hbus_master.sv
module test_hbus_master;
  localparam int CLK_PS = 4000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_done = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        busy;
  logic        bus_cs_n, bus_rd_n, bus_wr_n, bus_data_oe;
  logic [7:0]  bus_addr;
  logic [15:0] bus_data_o;
  logic [15:0] bus_data_i;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  hbus_master i_hbus_master (
    .clk(clk), .rst_n(rst_n), .boot_done(boot_done),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .busy(busy),
    .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_addr(bus_addr), .bus_data_o(bus_data_o), .bus_data_oe(bus_data_oe),
    .bus_data_i(bus_data_i)
  );

  function automatic logic [15:0] slave_val(input logic [7:0] a);
    return {~a, a} ^ 16'h5A3C;
  endfunction

  // Slave drives only while a read access is active.
  assign bus_data_i = (!bus_cs_n && !bus_rd_n) ? slave_val(bus_addr) : 16'h0000;

  function automatic int cyc(input int ps);
    return (ps + CLK_PS - 1) / CLK_PS;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
  function automatic int exp_act(input bit run);
    int p = run ? 15400 : 100000;
    return mx(cyc(p + 10000), mx(cyc(21000), cyc(20000)));
  endfunction
  function automatic int exp_gap(input bit run);
    int p = run ? 15400 : 100000;
    return cyc(2 * p + 10000);
  endfunction
  localparam int EXP_SETUP = 2;
  localparam int EXP_HOLD  = 2;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  typedef struct {
    int setup, act, gap, oe_pre, oe_act, oe_gap;
    int bad_strobe, bad_addr, bad_wdata, bad_ready;
    int done_first, done_later;
    logic [15:0] rdat;
  } meas_t;

  task automatic run_xfer(input bit wr, input logic [7:0] a, input logic [15:0] d,
                          output meas_t m);
    m = '{default: 0};
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~a; req_wdata = ~d;
    while (bus_cs_n && busy) begin
      m.setup++;
      if (bus_data_oe) m.oe_pre++;
      if (bus_addr != a) m.bad_addr++;
      if (req_ready == busy) m.bad_ready++;
      @(negedge clk);
    end
    while (!bus_cs_n) begin
      m.act++;
      if (wr ? (bus_wr_n || !bus_rd_n) : (bus_rd_n || !bus_wr_n)) m.bad_strobe++;
      if (bus_data_oe) m.oe_act++;
      if (wr && bus_data_o != d) m.bad_wdata++;
      if (bus_addr != a) m.bad_addr++;
      if (rsp_valid) m.done_later++;
      @(negedge clk);
    end
    m.done_first = rsp_valid;
    m.rdat = rsp_rdata;
    while (busy) begin
      m.gap++;
      if (m.gap > 1 && rsp_valid) m.done_later++;
      if (bus_data_oe) m.oe_gap++;
      if (!bus_rd_n || !bus_wr_n || !bus_cs_n) m.bad_strobe++;
      if (bus_addr != a) m.bad_addr++;
      if (wr && bus_data_oe && bus_data_o != d) m.bad_wdata++;
      if (req_ready == busy) m.bad_ready++;
      @(negedge clk);
    end
  endtask

  task automatic check_xfer(input string tag, input bit wr, input bit run,
                            input logic [7:0] a, input meas_t m);
    chk("R3", {tag, " setup cycles"}, m.setup, EXP_SETUP);
    chk("R4", {tag, " active cycles"}, m.act, exp_act(run));
    chk("R5", {tag, " gap cycles"}, m.gap, exp_gap(run));
    chk("R5", {tag, " address moves"}, m.bad_addr, 0);
    chk("R2", {tag, " strobe errors"}, m.bad_strobe, 0);
    chk("R1", {tag, " ready/busy mismatch"}, m.bad_ready, 0);
    chk("R7", {tag, " done pulse at gap start"}, m.done_first, 1);
    chk("R7", {tag, " stray done"}, m.done_later, 0);
    chk("R8", {tag, " profile"}, m.act + m.gap, exp_act(run) + exp_gap(run));
    if (wr) begin
      chk("R6", {tag, " oe in setup"}, m.oe_pre, EXP_SETUP);
      chk("R6", {tag, " oe in active"}, m.oe_act, exp_act(run));
      chk("R6", {tag, " oe hold"}, m.oe_gap, EXP_HOLD);
      chk("R6", {tag, " write data"}, m.bad_wdata, 0);
    end else begin
      chk("R6", {tag, " oe on read"}, m.oe_pre + m.oe_act + m.oe_gap, 0);
      chk("R7", {tag, " read data"}, int'(m.rdat), int'(slave_val(a)));
    end
  endtask

  task automatic t_reset();
    chk("R9", "cs_n", int'(bus_cs_n), 1);
    chk("R9", "rd_n", int'(bus_rd_n), 1);
    chk("R9", "wr_n", int'(bus_wr_n), 1);
    chk("R9", "oe", int'(bus_data_oe), 0);
    chk("R9", "busy", int'(busy), 0);
    chk("R9", "req_ready", int'(req_ready), 1);
    chk("R9", "rsp_valid", int'(rsp_valid), 0);
  endtask

  task automatic t_read_boot();
    meas_t m;
    boot_done = 1'b0;
    run_xfer(1'b0, 8'h3C, 16'h0000, m);
    check_xfer("boot read", 1'b0, 1'b0, 8'h3C, m);
  endtask

  task automatic t_write_boot();
    meas_t m;
    boot_done = 1'b0;
    run_xfer(1'b1, 8'hA5, 16'hBEEF, m);
    check_xfer("boot write", 1'b1, 1'b0, 8'hA5, m);
  endtask

  task automatic t_run_mixed();
    meas_t m;
    boot_done = 1'b1;
    run_xfer(1'b1, 8'h11, 16'h1234, m);
    check_xfer("run write", 1'b1, 1'b1, 8'h11, m);
    run_xfer(1'b0, 8'hF0, 16'h0000, m);
    check_xfer("run read after write", 1'b0, 1'b1, 8'hF0, m);
    run_xfer(1'b0, 8'h00, 16'h0000, m);
    check_xfer("run read after read", 1'b0, 1'b1, 8'h00, m);
  endtask

  task automatic t_profile_switch();
    meas_t m;
    boot_done = 1'b0;
    fork
      run_xfer(1'b0, 8'h5A, 16'h0000, m);
      begin repeat (4) @(negedge clk); boot_done = 1'b1; end
    join
    check_xfer("R8 switch mid-transfer", 1'b0, 1'b0, 8'h5A, m);
    run_xfer(1'b0, 8'h5B, 16'h0000, m);
    check_xfer("R8 next after switch", 1'b0, 1'b1, 8'h5B, m);
  endtask

  task automatic t_busy_ignore();
    meas_t m;
    int extra;
    boot_done = 1'b1;
    fork
      run_xfer(1'b0, 8'h77, 16'h0000, m);
      begin
        repeat (5) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h99; req_wdata = 16'hCAFE;
        repeat (6) @(negedge clk);
        req_valid = 1'b0;
      end
    join
    check_xfer("R1 busy request", 1'b0, 1'b1, 8'h77, m);
    extra = 0;
    for (int i = 0; i < 8; i++) begin
      if (busy || !bus_cs_n || !bus_wr_n || bus_data_oe || rsp_valid) extra++;
      @(negedge clk);
    end
    chk("R1", "activity after ignored request", extra, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_boot();
    t_write_boot();
    t_run_mixed();
    t_profile_switch();
    t_busy_ignore();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule